// File: doc/BRIEF.md
# Context-Pointer Register Window

This block gives a processor core sixteen word-wide general-purpose registers without keeping them in a register file of their own. The registers are a window of consecutive words inside a shared, word-addressed internal RAM. A context-pointer register holds the byte address where the window starts. Register number `n` maps to RAM word `(contextPointer / 2) + n`. Loading a new context pointer moves the window, and that is a complete bank switch in one cycle.

Windows placed at different pointers can overlap. The upper registers of one bank can then be the lower registers of the next, so a caller hands arguments to a callee without copying them. The block has two combinational register read ports and one register write port. It also has a direct word port into the same RAM. Same-cycle writes are forwarded to every reader, so the register view and the direct view always agree. A flag reports a pointer that pushes part of the window past the last RAM word. Register accesses that land beyond the RAM read zero and write nothing.

Top module: `cpbank_top`

## Requirements
- R1: After reset the context pointer reads 0 and the window-error flag is low.
- R2: A register read of index n (4-bit, 0 to 15) returns RAM word `cpValue/2 + n`, where that word was written earlier through the direct port.
- R3: A register write of index n stores its data at RAM word `cpValue/2 + n`, and a later direct read of that word returns it.
- R4: Bit 0 of a written pointer is dropped. `cpValue` always reads back even, and the window starts at word `cpWrData >> 1`.
- R5: A pointer load takes effect on the clock edge where `cpWrEn` is high. Accesses in that same cycle still use the old window. Without `cpWrEn` the pointer holds its value.
- R6: When a register read addresses the same RAM word as the register write in the same cycle, the read returns the write data. This applies to both read ports.
- R7: A direct write to a word inside the active window is forwarded to a register read of that slot in the same cycle, and it is returned by every later read of that slot.
- R8: Banks overlap. With the pointer raised by 2*k bytes, register n of the new bank is register n+k of the old bank.
- R9: `addrErr` is high exactly when `cpValue/2 + 15` is at or beyond `RAM_WORDS`.
- R10: A register access whose word address is at or beyond `RAM_WORDS` reads as 0. A register write to such an address changes no RAM word, including word 0.
- R11: When the register write and a direct write hit the same word in one cycle, the register write data is stored. `memRdata` shows the register write data in that cycle.
- R12: `memRdata` returns the stored word at `memAddr`. A same-cycle write to that word is returned instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the pointer |
| cpWrEn | input | 1 | Load the context pointer |
| cpWrData | input | AW+1 | New pointer, byte address |
| cpValue | output | AW+1 | Current pointer, word aligned |
| addrErr | output | 1 | Window extends past the last RAM word |
| rdIdxA | input | 4 | Register index, read port A |
| rdDataA | output | DATA_W | Read data, port A |
| rdIdxB | input | 4 | Register index, read port B |
| rdDataB | output | DATA_W | Read data, port B |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | 4 | Register index to write |
| wrData | input | DATA_W | Register write data |
| memWe | input | 1 | Direct RAM write enable |
| memAddr | input | AW | Direct RAM word address |
| memWdata | input | DATA_W | Direct write data |
| memRdata | output | DATA_W | Direct read data |

## Verification
The bench builds the block with `RAM_WORDS = 64`, `DATA_W = 16` and sixteen registers. At that size a 7-bit pointer covers the whole RAM. Random pointer values therefore often produce windows that overlap each other, and windows that run off the top of the RAM. Directed cases cover the edge of the error flag at word 48 (no error) and word 49 (error). They also check that a register write beyond the RAM does not wrap around to word 0. The random cycles then mix register writes, direct writes and pointer loads in the same cycle across the whole address range.

// File: rtl/cpbank_pkg.sv
package cpbank_pkg;

  // Per-cycle strobes passed from control to datapath
  typedef struct packed {
    logic regWrGo;   // register write lands in RAM
    logic memWrGo;   // direct write lands in RAM
    logic aOk;       // port A address inside RAM
    logic aFromReg;  // port A forwards register write data
    logic aFromMem;  // port A forwards direct write data
    logic bOk;
    logic bFromReg;
    logic bFromMem;
    logic mFromReg;  // direct read forwards register write data
    logic mFromMem;  // direct read forwards direct write data
  } bankStrobe_t;

endpackage

// File: rtl/cpbank_ctrl.sv
module cpbank_ctrl
  import cpbank_pkg::*;
#(
  parameter int RAM_WORDS = 1024,
  parameter int REG_COUNT = 16,
  parameter int AW        = $clog2(RAM_WORDS),
  parameter int IW        = $clog2(REG_COUNT)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpWrEn,
  input  logic [AW:0]   cpWrData,
  input  logic [IW-1:0] rdIdxA,
  input  logic [IW-1:0] rdIdxB,
  input  logic          wrEn,
  input  logic [IW-1:0] wrIdx,
  input  logic          memWe,
  input  logic [AW-1:0] memAddr,
  output logic [AW:0]   cpValue,
  output logic          addrErr,
  output logic [AW-1:0] physA,
  output logic [AW-1:0] physB,
  output logic [AW-1:0] physW,
  output bankStrobe_t   strobe
);

  localparam int SW = AW + 1;
  localparam int NPORT = 3;  // A, B, write

  logic [AW:0]   cpReg;
  logic [AW-1:0] cpWord;
  logic [SW-1:0] windowEnd;
  logic [IW-1:0] portIdx [NPORT];
  logic [SW-1:0] portSum [NPORT];
  logic          portOk  [NPORT];
  logic          memOk;

  // Pointer register; bit 0 dropped on load
  always_ff @(posedge clk) begin
    if (!rstN)       cpReg <= '0;
    else if (cpWrEn) cpReg <= {cpWrData[AW:1], 1'b0};
  end

  assign cpValue   = cpReg;
  assign cpWord    = cpReg[AW:1];
  assign windowEnd = {1'b0, cpWord} + SW'(REG_COUNT - 1);
  assign addrErr   = windowEnd >= SW'(RAM_WORDS);

  assign portIdx[0] = rdIdxA;
  assign portIdx[1] = rdIdxB;
  assign portIdx[2] = wrIdx;

  // Address adder and range check per register port
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign portSum[p] = {1'b0, cpWord} + SW'(portIdx[p]);
    assign portOk[p]  = portSum[p] < SW'(RAM_WORDS);
  end

  assign physA = portSum[0][AW-1:0];
  assign physB = portSum[1][AW-1:0];
  assign physW = portSum[2][AW-1:0];
  assign memOk = {1'b0, memAddr} < SW'(RAM_WORDS);

  always_comb begin
    strobe          = '0;
    strobe.regWrGo  = wrEn && portOk[2];
    strobe.memWrGo  = memWe && memOk;
    strobe.aOk      = portOk[0];
    strobe.bOk      = portOk[1];
    strobe.aFromReg = strobe.regWrGo && (physW == physA);
    strobe.aFromMem = strobe.memWrGo && (memAddr == physA);
    strobe.bFromReg = strobe.regWrGo && (physW == physB);
    strobe.bFromMem = strobe.memWrGo && (memAddr == physB);
    strobe.mFromReg = strobe.regWrGo && (physW == memAddr);
    strobe.mFromMem = strobe.memWrGo;
  end

endmodule

// File: rtl/cpbank_datapath.sv
module cpbank_datapath
  import cpbank_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int RAM_WORDS = 1024,
  parameter int AW        = $clog2(RAM_WORDS)
) (
  input  logic              clk,
  input  bankStrobe_t       strobe,
  input  logic [AW-1:0]     physA,
  input  logic [AW-1:0]     physB,
  input  logic [AW-1:0]     physW,
  input  logic [AW-1:0]     memAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] memRdata
);

  logic [DATA_W-1:0] ramQ [RAM_WORDS];

  // Register write is applied last so it wins a same-word collision
  always_ff @(posedge clk) begin
    if (strobe.memWrGo) ramQ[memAddr] <= memWdata;
    if (strobe.regWrGo) ramQ[physW]   <= wrData;
  end

  function automatic logic [DATA_W-1:0] pickWord(
    input logic ok, input logic fromReg, input logic fromMem,
    input logic [DATA_W-1:0] regD, input logic [DATA_W-1:0] memD,
    input logic [DATA_W-1:0] stored);
    if (!ok)         return '0;
    else if (fromReg) return regD;
    else if (fromMem) return memD;
    else              return stored;
  endfunction

  assign rdDataA  = pickWord(strobe.aOk, strobe.aFromReg, strobe.aFromMem,
                             wrData, memWdata, ramQ[physA]);
  assign rdDataB  = pickWord(strobe.bOk, strobe.bFromReg, strobe.bFromMem,
                             wrData, memWdata, ramQ[physB]);
  assign memRdata = pickWord(1'b1, strobe.mFromReg, strobe.mFromMem,
                             wrData, memWdata, ramQ[memAddr]);

endmodule

// File: rtl/cpbank_top.sv
module cpbank_top
  import cpbank_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int RAM_WORDS = 1024,
  parameter int REG_COUNT = 16,
  localparam int AW       = $clog2(RAM_WORDS),
  localparam int IW       = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpWrEn,
  input  logic [AW:0]       cpWrData,
  output logic [AW:0]       cpValue,
  output logic              addrErr,
  input  logic [IW-1:0]     rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IW-1:0]     rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IW-1:0]     wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              memWe,
  input  logic [AW-1:0]     memAddr,
  input  logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] memRdata
);

  bankStrobe_t   strobe;
  logic [AW-1:0] physA, physB, physW;

  cpbank_ctrl #(
    .RAM_WORDS(RAM_WORDS), .REG_COUNT(REG_COUNT), .AW(AW), .IW(IW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cpWrEn(cpWrEn), .cpWrData(cpWrData),
    .rdIdxA(rdIdxA), .rdIdxB(rdIdxB), .wrEn(wrEn), .wrIdx(wrIdx),
    .memWe(memWe), .memAddr(memAddr), .cpValue(cpValue), .addrErr(addrErr),
    .physA(physA), .physB(physB), .physW(physW), .strobe(strobe)
  );

  cpbank_datapath #(
    .DATA_W(DATA_W), .RAM_WORDS(RAM_WORDS), .AW(AW)
  ) dp_i (
    .clk(clk), .strobe(strobe), .physA(physA), .physB(physB), .physW(physW),
    .memAddr(memAddr), .wrData(wrData), .memWdata(memWdata),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .memRdata(memRdata)
  );

endmodule

// File: rtl/cpbank_chk.sv
module cpbank_chk #(
  parameter int DATA_W    = 16,
  parameter int RAM_WORDS = 1024,
  parameter int REG_COUNT = 16,
  localparam int AW       = $clog2(RAM_WORDS),
  localparam int IW       = $clog2(REG_COUNT)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpWrEn,
  input logic [AW:0]       cpWrData,
  input logic [AW:0]       cpValue,
  input logic              addrErr,
  input logic [IW-1:0]     rdIdxA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [IW-1:0]     rdIdxB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [IW-1:0]     wrIdx,
  input logic [DATA_W-1:0] wrData,
  input logic              memWe,
  input logic [AW-1:0]     memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic [DATA_W-1:0] memRdata
);

  localparam int SW = AW + 2;

  logic [SW-1:0] baseW, endA, endW;
  logic          aIn, wIn, wHitsMem;

  assign baseW    = SW'(cpValue[AW:1]);
  assign endA     = baseW + SW'(rdIdxA);
  assign endW     = baseW + SW'(wrIdx);
  assign aIn      = endA < SW'(RAM_WORDS);
  assign wIn      = endW < SW'(RAM_WORDS);
  assign wHitsMem = wrEn && wIn && (endW == SW'(memAddr));

  assert_cp_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    cpWrEn |=> cpValue == {$past(cpWrData[AW:1]), 1'b0});

  assert_cp_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cpWrEn |=> $stable(cpValue));

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !addrErr |-> (baseW + SW'(REG_COUNT) <= SW'(RAM_WORDS)));

  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> (baseW + SW'(REG_COUNT) > SW'(RAM_WORDS)));

  assert_oob_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !aIn |-> rdDataA == '0);

  assert_rdw_fwd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wIn && wrIdx == rdIdxA) |-> rdDataA == wrData);

  assert_wr_win_R11: assert property (@(posedge clk) disable iff (!rstN)
    wHitsMem |-> memRdata == wrData);

  assert_mem_fwd_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !wHitsMem) |-> memRdata == memWdata);

endmodule

bind cpbank_top cpbank_chk #(
  .DATA_W(DATA_W), .RAM_WORDS(RAM_WORDS), .REG_COUNT(REG_COUNT)
) chk_i (.*);

// File: tb/cpbank_tb.sv
`timescale 1ns/1ps
module cpbank_top_tb_top;

  localparam int DW = 16;
  localparam int NW = 64;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cpWrEn;
  logic [AW:0]   cpWrData;
  logic [AW:0]   cpValue;
  logic          addrErr;
  logic [3:0]    rdIdxA, rdIdxB, wrIdx;
  logic [DW-1:0] rdDataA, rdDataB, wrData, memWdata, memRdata;
  logic          wrEn, memWe;
  logic [AW-1:0] memAddr;

  int total = 0;
  int failed = 0;
  bit done = 0;

  logic [DW-1:0] model [NW];
  int mcp = 0;  // model window base, in words

  always #2.5 clk = ~clk;

  cpbank_top #(.DATA_W(DW), .RAM_WORDS(NW), .REG_COUNT(16)) dut_i (.*);

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  // Expected read of word phys in the current cycle
  function automatic logic [DW-1:0] expWord(int phys, int wPhys);
    if (phys >= NW) return '0;
    if (wrEn && wPhys < NW && wPhys == phys) return wrData;
    if (memWe && int'(memAddr) == phys) return memWdata;
    return model[phys];
  endfunction

  task automatic idle();
    cpWrEn = 0; cpWrData = '0; wrEn = 0; wrIdx = '0; wrData = '0;
    memWe = 0; memAddr = '0; memWdata = '0; rdIdxA = '0; rdIdxB = '0;
  endtask

  // Check all outputs for the driven inputs, clock once, update the model
  task automatic step(string tag);
    int pa, pb, pw;
    #1;
    pa = mcp + int'(rdIdxA);
    pb = mcp + int'(rdIdxB);
    pw = mcp + int'(wrIdx);
    chk({tag, " rdDataA"}, rdDataA, expWord(pa, pw));
    chk({tag, " rdDataB"}, rdDataB, expWord(pb, pw));
    chk({tag, " memRdata"}, memRdata, expWord(int'(memAddr), pw));
    chk({tag, " cpValue"}, DW'(cpValue), DW'(mcp * 2));
    chk({tag, " addrErr"}, DW'(addrErr), DW'(mcp + 15 >= NW));
    @(posedge clk);
    if (memWe) model[memAddr] = memWdata;
    if (wrEn && pw < NW) model[pw] = wrData;
    if (cpWrEn) mcp = int'(cpWrData) / 2;
    @(negedge clk);
  endtask

  task automatic setCp(int byteAddr, string tag);
    idle(); cpWrEn = 1; cpWrData = (AW+1)'(byteAddr); step(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    failed++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    chk("R1 cpValue after reset", DW'(cpValue), '0);
    chk("R1 addrErr after reset", DW'(addrErr), '0);

    // Preload every word through the direct port (R12 forwarding)
    for (int i = 0; i < NW; i++) begin
      idle(); memWe = 1; memAddr = AW'(i);
      memWdata = DW'(i * 16'h0101) ^ 16'hA5A5;
      step("R12 preload");
    end

    // R5: load in this cycle, read still uses old base 0
    idle(); cpWrEn = 1; cpWrData = 7'h20; rdIdxA = 4'd3; step("R5 old base");
    idle(); rdIdxA = 4'd3; rdIdxB = 4'd15; step("R2 new base");

    // R4: odd pointer aligned down
    setCp(8'h21, "R4 odd load");
    idle(); rdIdxA = 4'd0; step("R4 aligned read");

    // R3: register write then direct read of word 16+5
    idle(); wrEn = 1; wrIdx = 4'd5; wrData = 16'hBEEF; step("R3 reg write");
    idle(); memAddr = 6'd21; step("R3 direct read");

    // R6: read during write on both ports
    idle(); wrEn = 1; wrIdx = 4'd7; wrData = 16'h7777;
    rdIdxA = 4'd7; rdIdxB = 4'd7; step("R6 bypass");

    // R7: direct write into window, forwarded then stored
    idle(); memWe = 1; memAddr = 6'd25; memWdata = 16'h2525; rdIdxA = 4'd9;
    step("R7 same cycle");
    idle(); rdIdxB = 4'd9; step("R7 next cycle");

    // R8: overlapping banks
    idle(); wrEn = 1; wrIdx = 4'd12; wrData = 16'h1234; step("R8 write R12");
    setCp(56, "R8 move up");
    idle(); rdIdxA = 4'd0; wrEn = 1; wrIdx = 4'd1; wrData = 16'h4321;
    step("R8 new R0");
    setCp(32, "R8 move back");
    idle(); rdIdxA = 4'd12; rdIdxB = 4'd13; step("R8 old R13");

    // R9: flag boundary
    setCp(96, "R9 word48");
    idle(); step("R9 no error at 48");
    setCp(98, "R9 word49");
    idle(); step("R9 error at 49");

    // R10: out-of-range read zero, write dropped without wrap
    idle(); rdIdxA = 4'd15; rdIdxB = 4'd14; step("R10 read beyond");
    idle(); wrEn = 1; wrIdx = 4'd15; wrData = 16'hDEAD; memAddr = 6'd0;
    step("R10 write beyond");
    idle(); memAddr = 6'd0; rdIdxA = 4'd15; step("R10 word0 intact");

    // R11: collision, register write wins
    setCp(20, "R11 base");
    idle(); wrEn = 1; wrIdx = 4'd2; wrData = 16'hAAAA;
    memWe = 1; memAddr = 6'd12; memWdata = 16'h5555; step("R11 collide");
    idle(); memAddr = 6'd12; step("R11 stored");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      cpWrEn   = ($urandom % 8) == 0;
      cpWrData = (AW+1)'($urandom);
      rdIdxA   = 4'($urandom);
      rdIdxB   = 4'($urandom);
      wrEn     = ($urandom % 2) == 0;
      wrIdx    = 4'($urandom);
      wrData   = DW'($urandom);
      memWe    = ($urandom % 3) == 0;
      memAddr  = AW'($urandom);
      memWdata = DW'($urandom);
      step("R2 R3 R6 R7 R8 R10 R11 R12 random");
    end

    finishUp();
  end

endmodule